// File: doc/BRIEF.md
# Reciprocal Square-Root Estimator

This block produces a coarse approximation of 1/sqrt(x) for one IEEE-754 binary operand, accurate to about seven bits. A design-time parameter selects the operand format: half, single or double precision. The seed it returns is the usual starting point for a Newton-Raphson refinement in a vector or scalar floating-point unit. It also returns a five-bit exception vector, so the surrounding pipeline can merge the flags into its accrued state.

The operand is classified first. NaNs, infinities, zeros and negative values go to fixed results. Positive subnormal operands are pre-normalised with a leading-zero count. For every positive finite operand the result is built from three parts. One table output forms the leading seven fraction bits. The exponent comes from a simple halving formula. The sign is the operand's sign. A single register stage holds the result and its flags. Both are captured whenever the input is marked valid.

Top module: `rsqrt_est`

## Requirements
- R1: A quiet NaN operand of either sign (exponent all ones, fraction MSB set) yields the canonical NaN (sign 0, exponent all ones, fraction MSB 1, all other fraction bits 0; 0x7E00 in half precision) with all five flags clear.
- R2: A signalling NaN, negative infinity, or a negative nonzero finite operand yields the canonical NaN with only the invalid flag, out_flags bit 4, set.
- R3: An operand of +0 yields +infinity and -0 yields -infinity; only the divide-by-zero flag, out_flags bit 3, is set.
- R4: An operand of +infinity yields +0 with all flags clear.
- R5: For every positive finite operand the flags are all zero, the result sign is 0, and the fraction bits below the top seven are zero.
- R6: For a positive finite operand with normalised biased exponent n and bias B, the result exponent is floor((3B - 1 - n) / 2).
- R7: The top seven result fraction bits equal T[i], where i = {n[0], top six bits of the normalised fraction}. With s = i mod 64, f = (2s+1)/128 and c = 2 for i >= 64 or sqrt(2) for i < 64, T[i] = round(128*c/sqrt(1+f) - 128). Index 0 gives 52, index 63 gives 0, index 64 gives 127 and index 127 gives 53.
- R8: For a positive subnormal operand whose fraction has z leading zeros, n = -z. The normalised fraction is the operand fraction shifted left by z+1 and cut back to the fraction width.
- R9: out_valid follows in_valid one clock later. out_word and out_flags are loaded only on cycles with in_valid high and hold otherwise. Reset clears all three outputs to zero.
- R10: The flag vector is ordered {invalid, divide-by-zero, overflow, underflow, inexact} from bit 4 down to bit 0, and bits 2 to 0 are never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_word | input | W (1+EW+FW) | Operand bit pattern |
| out_valid | output | 1 | Registered result valid |
| out_word | output | W | Estimate or special-value result |
| out_flags | output | 5 | Exception flags {NV, DZ, OF, UF, NX} |

## Verification
The bench sweeps every one of the 65536 half-precision patterns and compares each one with an arithmetic model that uses real-valued square roots. That model never consults an integer table. Some errors show up as a skewed table entry near a rounding boundary: an off-by-one seed. Others show up as a wrong half of the table chosen on exponent parity: seeds near 0.7 where 1.0 is due. A leading-zero count that is off by one shows up in the smallest subnormals, with an exponent that is one too large or a fraction that is shifted wrongly. Wrong special-case handling shows up as a NaN without the invalid flag, a signed zero mapped to the opposite infinity, or a negative quiet NaN flagged as invalid. Named checks also change the operand while in_valid is low and confirm the registered result does not move.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  localparam int FMT_HALF   = 0;
  localparam int FMT_SINGLE = 1;
  localparam int FMT_DOUBLE = 2;

  // Flag vector bit positions
  localparam int FLG_NV = 4;
  localparam int FLG_DZ = 3;
  localparam int FLG_OF = 2;
  localparam int FLG_UF = 1;
  localparam int FLG_NX = 0;

  typedef enum logic [2:0] {
    CLS_QNAN,
    CLS_INVALID,
    CLS_ZERO,
    CLS_POS_INF,
    CLS_POS_SUB,
    CLS_POS_NORM
  } op_class_e;

  function automatic int exp_bits(input int fmt);
    case (fmt)
      FMT_HALF:   return 5;
      FMT_SINGLE: return 8;
      default:    return 11;
    endcase
  endfunction

  function automatic int frac_bits(input int fmt);
    case (fmt)
      FMT_HALF:   return 10;
      FMT_SINGLE: return 23;
      default:    return 52;
    endcase
  endfunction

  // Seed table entry: round(P*c/sqrt(1+(2s+1)/P) - P), c = 2 (upper half)
  // or sqrt(2) (lower half), computed with an integer square root of
  // 4*P^3*k/(P+2s+1) where k = c^2.
  function automatic int est_entry(input int est, input int idx);
    longint p, s, k, num, den, q, trial, r;
    p   = longint'(1) << est;
    s   = longint'(idx) % (p / 2);
    k   = (longint'(idx) >= p / 2) ? 4 : 2;
    num = 4 * p * p * p * k;
    den = p + 2 * s + 1;
    q   = 0;
    for (int b = est + 2; b >= 0; b--) begin
      trial = q + (longint'(1) << b);
      if (trial * trial * den <= num) q = trial;
    end
    r = (q + 1) / 2 - p;
    if (r < 0) r = 0;
    if (r > p - 1) r = p - 1;
    return int'(r);
  endfunction

endpackage

// File: rtl/rsq_classify.sv
module rsq_classify
  import rsq_pkg::*;
#(
  parameter int EW = 5,
  parameter int FW = 10
) (
  input  logic [EW+FW:0] op,
  output op_class_e      cls,
  output logic [EW-1:0]  exp_o,
  output logic [FW-1:0]  frac_o
);

  logic sign_w, exp_ones, exp_zero, frac_zero, quiet;

  assign sign_w    = op[EW+FW];
  assign exp_o     = op[EW+FW-1:FW];
  assign frac_o    = op[FW-1:0];
  assign exp_ones  = &exp_o;
  assign exp_zero  = ~|exp_o;
  assign frac_zero = ~|frac_o;
  assign quiet     = frac_o[FW-1];

  always_comb begin
    if (exp_ones) begin
      if (!frac_zero) cls = quiet ? CLS_QNAN : CLS_INVALID;
      else            cls = sign_w ? CLS_INVALID : CLS_POS_INF;
    end else if (exp_zero && frac_zero) begin
      cls = CLS_ZERO;
    end else if (sign_w) begin
      cls = CLS_INVALID;
    end else if (exp_zero) begin
      cls = CLS_POS_SUB;
    end else begin
      cls = CLS_POS_NORM;
    end
  end

endmodule

// File: rtl/rsq_lzc.sv
module rsq_lzc #(
  parameter int WIDTH = 10,
  parameter int CW    = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [CW-1:0]    zeros
);

  // Highest set bit wins because later iterations overwrite earlier ones.
  always_comb begin
    zeros = CW'(WIDTH);
    for (int i = 0; i < WIDTH; i++) begin
      if (vec[i]) zeros = CW'(WIDTH - 1 - i);
    end
  end

endmodule

// File: rtl/rsq_prenorm.sv
module rsq_prenorm #(
  parameter int EW  = 5,
  parameter int FW  = 10,
  parameter int EST = 7,
  parameter int CW  = $clog2(FW + 1)
) (
  input  logic [EW-1:0]  exp_f,
  input  logic [FW-1:0]  frac_f,
  input  logic           is_sub,
  input  logic [CW-1:0]  lz,
  output logic           exp_par,
  output logic [EST-2:0] sig_top,
  output logic [EW-1:0]  res_exp
);

  localparam int NW = EW + 2;
  localparam int SW = FW + EST - 1;
  localparam logic [NW-1:0] K3B = NW'(3 * ((1 << (EW - 1)) - 1) - 1);

  // floor((3B - 1 - n)/2), with n = -lz for subnormals
  function automatic logic [EW-1:0] f_res_exp(input logic sub,
                                               input logic [EW-1:0] e,
                                               input logic [CW-1:0] z);
    logic [NW-1:0] num;
    if (sub) num = K3B + NW'(z);
    else     num = K3B - NW'(e);
    return num[EW:1];
  endfunction

  // Top bits of (frac << (z+1)) taken from a right shift of a widened copy
  function automatic logic [EST-2:0] f_sub_top(input logic [FW-1:0] f,
                                               input logic [CW-1:0] z);
    logic [SW-1:0] ext;
    ext = {f, {(EST-1){1'b0}}};
    return (EST-1)'(ext >> (FW - 1 - int'(z)));
  endfunction

  assign exp_par = is_sub ? lz[0] : exp_f[0];
  assign sig_top = is_sub ? f_sub_top(frac_f, lz) : frac_f[FW-1 -: EST-1];
  assign res_exp = f_res_exp(is_sub, exp_f, lz);

endmodule

// File: rtl/rsq_est_rom.sv
module rsq_est_rom #(
  parameter int EST = 7
) (
  input  logic [EST-1:0] idx,
  output logic [EST-1:0] val
);

  localparam int DEPTH = 1 << EST;

  logic [EST-1:0] rom [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    localparam int ENT = rsq_pkg::est_entry(EST, gi);
    assign rom[gi] = EST'(ENT);
  end

  assign val = rom[idx];

endmodule

// File: rtl/rsqrt_est.sv
module rsqrt_est
  import rsq_pkg::*;
#(
  parameter int FMT      = FMT_HALF,
  parameter int EST_BITS = 7,
  localparam int EW      = exp_bits(FMT),
  localparam int FW      = frac_bits(FMT),
  localparam int W       = 1 + EW + FW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_word,
  output logic         out_valid,
  output logic [W-1:0] out_word,
  output logic [4:0]   out_flags
);

  localparam int CW = $clog2(FW + 1);
  localparam logic [W-1:0] CANON_NAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};
  localparam logic [4:0]   F_NV = 5'(1 << FLG_NV);
  localparam logic [4:0]   F_DZ = 5'(1 << FLG_DZ);

  op_class_e         cls;
  logic [EW-1:0]     exp_f;
  logic [FW-1:0]     frac_f;
  logic              sub_in;
  logic [CW-1:0]     lz_cnt;
  logic              exp_par;
  logic [EST_BITS-2:0] sig_top;
  logic [EW-1:0]     res_exp;
  logic [EST_BITS-1:0] tbl_idx;
  logic [EST_BITS-1:0] tbl_val;
  logic [W-1:0]      est_word;
  logic [W-1:0]      nxt_word;
  logic [4:0]        nxt_flags;

  rsq_classify #(.EW(EW), .FW(FW)) u_cls (
    .op    (in_word),
    .cls   (cls),
    .exp_o (exp_f),
    .frac_o(frac_f)
  );

  assign sub_in = (cls == CLS_POS_SUB);

  rsq_lzc #(.WIDTH(FW), .CW(CW)) u_lzc (
    .vec  (frac_f),
    .zeros(lz_cnt)
  );

  rsq_prenorm #(.EW(EW), .FW(FW), .EST(EST_BITS), .CW(CW)) u_norm (
    .exp_f  (exp_f),
    .frac_f (frac_f),
    .is_sub (sub_in),
    .lz     (lz_cnt),
    .exp_par(exp_par),
    .sig_top(sig_top),
    .res_exp(res_exp)
  );

  assign tbl_idx = {exp_par, sig_top};

  rsq_est_rom #(.EST(EST_BITS)) u_rom (
    .idx(tbl_idx),
    .val(tbl_val)
  );

  assign est_word = {1'b0, res_exp, tbl_val, {(FW-EST_BITS){1'b0}}};

  always_comb begin
    nxt_word  = est_word;
    nxt_flags = '0;
    case (cls)
      CLS_QNAN:    nxt_word = CANON_NAN;
      CLS_INVALID: begin nxt_word = CANON_NAN; nxt_flags = F_NV; end
      CLS_ZERO:    begin
        nxt_word  = {in_word[W-1], {EW{1'b1}}, {FW{1'b0}}};
        nxt_flags = F_DZ;
      end
      CLS_POS_INF: nxt_word = '0;
      default:     nxt_word = est_word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word  <= nxt_word;
        out_flags <= nxt_flags;
      end
    end
  end

endmodule

// File: rtl/rsqrt_est_chk.sv
module rsqrt_est_chk #(
  parameter int EW  = 5,
  parameter int FW  = 10,
  parameter int EST = 7,
  parameter int CW  = $clog2(FW + 1),
  localparam int W  = 1 + EW + FW
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         out_valid,
  input logic [W-1:0] out_word,
  input logic [4:0]   out_flags,
  input logic         sub_in,
  input logic [CW-1:0] lz_cnt
);

  localparam logic [W-1:0] CNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

  assert_canon_nan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[4] |-> out_word == CNAN);

  assert_dz_inf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[3] |-> out_word[W-2:0] == {{EW{1'b1}}, {FW{1'b0}}});

  assert_one_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_flags));

  assert_no_of_uf_nx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_flags[2:0] == 3'b000);

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word) && $stable(out_flags));

  assert_est_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags == 5'b0 && !(&out_word[W-2:FW]) && (|out_word[W-2:FW])
      |-> !out_word[W-1] && out_word[FW-EST-1:0] == '0);

  assert_lz_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sub_in |-> lz_cnt < CW'(FW));

endmodule

bind rsqrt_est rsqrt_est_chk #(.EW(EW), .FW(FW), .EST(EST_BITS), .CW(CW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .out_word (out_word),
  .out_flags(out_flags),
  .sub_in   (sub_in),
  .lz_cnt   (lz_cnt)
);

// File: tb/rsqrt_est_tb_top.sv
module rsqrt_est_tb_top;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_word = '0;
  logic         out_valid;
  logic [W-1:0] out_word;
  logic [4:0]   out_flags;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  rsqrt_est #(.FMT(0), .EST_BITS(7)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_word  (in_word),
    .out_valid(out_valid),
    .out_word (out_word),
    .out_flags(out_flags)
  );

  // Seed value from real arithmetic (R7)
  function automatic int tb_seed(input int idx);
    real f, c, v;
    int t;
    f = (2.0 * real'(idx % 64) + 1.0) / 128.0;
    c = (idx >= 64) ? 2.0 : $sqrt(2.0);
    v = 128.0 * c / $sqrt(1.0 + f) - 128.0;
    t = $rtoi(v + 0.5);
    if (t < 0) t = 0;
    if (t > 127) t = 127;
    return t;
  endfunction

  // Half-precision model: returns {flags, word}
  function automatic logic [20:0] tb_model(input logic [15:0] x);
    logic [4:0] e;
    logic [10:0] m;
    int ne, idx, ex;
    e = x[14:10];
    if (e == 5'h1F) begin
      if (x[9:0] != 0) return x[9] ? {5'b00000, 16'h7E00} : {5'b10000, 16'h7E00};
      return x[15] ? {5'b10000, 16'h7E00} : {5'b00000, 16'h0000};
    end
    if (x[14:0] == 0) return {5'b01000, x[15], 5'h1F, 10'h000};
    if (x[15]) return {5'b10000, 16'h7E00};
    if (e == 0) begin
      m  = {1'b0, x[9:0]};
      ne = 1;
      while (!m[10]) begin
        m  = m << 1;
        ne = ne - 1;
      end
    end else begin
      m  = {1'b1, x[9:0]};
      ne = int'(e);
    end
    idx = ((ne & 1) * 64) + int'(m[9:4]);
    ex  = (44 - ne) / 2;
    return {5'b00000, 1'b0, 5'(ex), 7'(tb_seed(idx)), 3'b000};
  endfunction

  function automatic string tb_tag(input logic [15:0] x);
    if (x[14:10] == 5'h1F && x[9:0] != 0) return x[9] ? "R1" : "R2";
    if (x[14:0] == 0) return "R3";
    if (x[14:0] == 15'h7C00) return x[15] ? "R2" : "R4";
    if (x[15]) return "R2";
    if (x[14:10] == 0) return "R8 R5";
    return "R5 R6 R7";
  endfunction

  task automatic check(input string req, input logic [W-1:0] aw, input logic [W-1:0] ew,
                       input logic [4:0] af, input logic [4:0] ef);
    n_checks++;
    if (aw !== ew || af !== ef) begin
      n_fail++;
      $display("FAIL %s: actual word=%h flags=%b expected word=%h flags=%b", req, aw, af, ew, ef);
    end
  endtask

  task automatic apply(input logic [15:0] x);
    in_word  = x;
    in_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic named(input string req, input logic [15:0] x, input logic [15:0] ew, input logic [4:0] ef);
    apply(x);
    check(req, out_word, ew, out_flags, ef);
  endtask

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R9: watchdog expired, actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [20:0] r;
    repeat (3) @(negedge clk);
    // R9 reset state
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R9: reset out_valid actual=%b expected=0", out_valid);
    end
    check("R9 reset", out_word, 16'h0000, out_flags, 5'b00000);
    rst_n = 1'b1;
    @(negedge clk);

    named("R1 quiet NaN", 16'h7E00, 16'h7E00, 5'b00000);
    named("R1 negative quiet NaN", 16'hFE00, 16'h7E00, 5'b00000);
    named("R2 signalling NaN", 16'h7D00, 16'h7E00, 5'b10000);
    named("R2 negative infinity", 16'hFC00, 16'h7E00, 5'b10000);
    named("R2 negative normal", 16'hBC00, 16'h7E00, 5'b10000);
    named("R2 negative subnormal", 16'h8001, 16'h7E00, 5'b10000);
    named("R3 plus zero", 16'h0000, 16'h7C00, 5'b01000);
    named("R3 minus zero", 16'h8000, 16'hFC00, 5'b01000);
    named("R4 plus infinity", 16'h7C00, 16'h0000, 5'b00000);
    named("R7 one, index 64", 16'h3C00, 16'h3BF8, 5'b00000);
    named("R7 two, index 0", 16'h4000, 16'h39A0, 5'b00000);
    named("R6 largest normal", 16'h7BFF, 16'h1C00, 5'b00000);
    named("R6 smallest normal", 16'h0400, 16'h57F8, 5'b00000);
    named("R8 smallest subnormal", 16'h0001, 16'h6BF8, 5'b00000);
    named("R8 subnormal lz 0", 16'h0200, 16'h59A0, 5'b00000);

    // R10 and all classes: exhaustive sweep
    for (int v = 0; v < 65536; v++) begin
      apply(16'(v));
      r = tb_model(16'(v));
      check(tb_tag(16'(v)), out_word, r[15:0], out_flags, r[20:16]);
      if (out_flags[2:0] !== 3'b000) begin
        n_checks++;
        n_fail++;
        $display("FAIL R10: flags[2:0] actual=%b expected=000", out_flags[2:0]);
      end
    end

    // R9: operand ignored while in_valid is low
    in_valid = 1'b0;
    in_word  = 16'h0000;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R9: out_valid actual=%b expected=0", out_valid);
    end
    check("R9 hold", out_word, 16'h7E00, out_flags, 5'b00000);
    in_word = 16'h8000;
    repeat (2) @(negedge clk);
    check("R9 hold later", out_word, 16'h7E00, out_flags, 5'b00000);
    named("R9 reload", 16'h8000, 16'hFC00, 5'b01000);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule